// File: doc/BRIEF.md
# Serial Control-Word Port with Transmit-Gain Select

This block is a write-only serial slave that configures a radio front end. A host frames each write by pulling a frame-select line low, then toggles a serial clock sixteen times while presenting one data bit per clock, most significant bit first. When the frame-select line returns high, the port commits the word. The low four bits of the word are an address that picks one of eight control registers. The upper twelve bits carry that register's fields.

The decoded fields are presented as ports:
- power state, band select, linearity, charge-pump and oscillator mode bits;
- spectral inversion;
- prescaler, and the RF divider words D, S, F and M;
- the IF divider words, which are passed out only while fractional IF mode is on;
- the effective five-bit transmit gain, together with its attenuation in dB.

The transmit gain comes from one of two sources, picked by a mode bit: the serial gain field, or five parallel gain pins. A range checker rejects RF divider values outside their legal span and flags the rejection.

All serial lines are oversampled by the system clock through synchronizers. Defaults are reloaded at reset and on every rising edge of the power-enable input. The port then stays deaf for a programmable wake-up window, which is 100 cycles by default (0.5 µs at 200 MHz).

Top module: `spw_port`

## Requirements
- R1: A frame is the sixteen bits sampled on serClk rising edges while wrFrameN is low, shifted in MSB first. The word is committed when wrFrameN rises. Bits [3:0] are the address, and the registers are laid out as follows:
  - address 1: psMode [15:14], bandA [13], gainSrcPin [12], fracIf [11], txHiLin [10], cpCont [9], xoLowPwr [8];
  - address 2: txGainSer [15:11], specInv [10];
  - address 3: rfM [15:9];
  - address 4: ifM [15:9];
  - address 5: rfF [15:9], prescale [8];
  - address 6: ifF [15:9];
  - address 7: rfD [15:11], rfS [10:8];
  - address 8: ifD [15:11], ifS [10:8].
- R2: A frame with any count of serClk rising edges other than sixteen is discarded, and no register changes.
- R3: A word whose address is 0 or 9 to 15 is discarded, and no register or flag changes.
- R4: Reset, and every rising edge of powerEn, load the defaults:
  - psMode 0, bandA 0, gainSrcPin 1, fracIf 0, txHiLin 0, cpCont 0, xoLowPwr 1;
  - txGainSer 0, specInv 1;
  - prescale 1, rfD 10, rfS 0, rfF 48, rfM 79;
  - ifD 16, ifS 2, ifF 32, ifM 79;
  - rfRangeErr 0.
- R5: portReady is low while powerEn is low, and for WAKE_CYCLES clocks after powerEn rises. Frames that end while portReady is low are ignored.
- R6: An address-7 word with D below 7, or an address-3 word with M below 32, is rejected. The whole register keeps its old value and rfRangeErr goes to 1. Any accepted word clears rfRangeErr.
- R7: With gainSrcPin 0, txGain equals txGainSer and the pins have no effect. With gainSrcPin 1, txGain follows gainPins. For both sources, code 31 is maximum gain and code 0 is minimum gain.
- R8: txAttenDb equals 31 minus txGain, so a 0 on pin or field bit 4, 3, 2, 1 or 0 adds 16, 8, 4, 2 or 1 dB of attenuation.
- R9: With fracIf 0, the ifD, ifS, ifF and ifM outputs read 0. With fracIf 1, they carry the stored IF divider values.
- R10: serClk edges while wrFrameN is high have no effect on the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rstN | input | 1 | Asynchronous active-low reset |
| powerEn | input | 1 | Power enable; a rising edge reloads the defaults |
| wrFrameN | input | 1 | Active-low frame select; a rising edge commits the word |
| serClk | input | 1 | Serial bit clock |
| serData | input | 1 | Serial data, MSB first |
| gainPins | input | 5 | Parallel transmit-gain code |
| portReady | output | 1 | Port accepts frames |
| psMode | output | 2 | Power-state field |
| bandA | output | 1 | Band select, 1 picks band A |
| specInv | output | 1 | Spectral inversion enable |
| txHiLin | output | 1 | Transmit high-linearity mode |
| cpCont | output | 1 | Charge-pump continuous-current mode |
| xoLowPwr | output | 1 | Oscillator low-power mode |
| prescale | output | 1 | Reference prescaler bit |
| rfD | output | 5 | RF divider D word |
| rfS | output | 3 | RF divider S word |
| rfF | output | 7 | RF divider F word |
| rfM | output | 7 | RF divider M word |
| ifFracOn | output | 1 | Fractional IF mode |
| ifD | output | 5 | IF divider D, gated by fractional mode |
| ifS | output | 3 | IF divider S, gated |
| ifF | output | 7 | IF divider F, gated |
| ifM | output | 7 | IF divider M, gated |
| gainSrcPin | output | 1 | Gain source, 1 selects the pins |
| txGain | output | 5 | Effective transmit-gain code |
| txAttenDb | output | 5 | Attenuation in dB below maximum gain |
| rfRangeErr | output | 1 | Last RF divider write was rejected |

## Verification
The bound checker covers four properties on every cycle:
- no word commits inside the wake-up window;
- defaults appear in the cycle after a reload;
- the RF divider outputs never leave their legal range, and hold steady when a rejection is flagged;
- the configuration fields stay still unless a commit or reload strobe fires.

Frame-length discard, unknown-address discard, the transmit-gain source selection and attenuation, IF gating and the stray serClk edges outside a frame can only be shown by the bench. The bench drives framed words and compares every output with its own model.

// File: rtl/spw_pkg.sv
package spw_pkg;
  localparam int GAIN_W = 5;
  localparam int DIV_W  = 7;
  localparam int DW_W   = 5;
  localparam int SW_W   = 3;
  localparam int PS_W   = 2;

  localparam logic [3:0] ADDR_MODE = 4'd1;
  localparam logic [3:0] ADDR_GAIN = 4'd2;
  localparam logic [3:0] ADDR_RFM  = 4'd3;
  localparam logic [3:0] ADDR_IFM  = 4'd4;
  localparam logic [3:0] ADDR_RFF  = 4'd5;
  localparam logic [3:0] ADDR_IFF  = 4'd6;
  localparam logic [3:0] ADDR_RFDS = 4'd7;
  localparam logic [3:0] ADDR_IFDS = 4'd8;

  typedef struct packed {
    logic shift;
    logic bitIn;
    logic commit;
    logic reload;
  } spStrobe_t;

  typedef struct packed {
    logic [PS_W-1:0]   psMode;
    logic              bandA;
    logic              gainSrcPin;
    logic              fracIf;
    logic              txHiLin;
    logic              cpCont;
    logic              xoLowPwr;
    logic [GAIN_W-1:0] txGainSer;
    logic              specInv;
    logic [DIV_W-1:0]  rfM;
    logic [DIV_W-1:0]  ifM;
    logic [DIV_W-1:0]  rfF;
    logic              prescale;
    logic [DIV_W-1:0]  ifF;
    logic [DW_W-1:0]   rfD;
    logic [SW_W-1:0]   rfS;
    logic [DW_W-1:0]   ifD;
    logic [SW_W-1:0]   ifS;
  } cfgRegs_t;

  function automatic cfgRegs_t cfgDefaults();
    cfgRegs_t c;
    c = '0;
    c.gainSrcPin = 1'b1;
    c.xoLowPwr   = 1'b1;
    c.specInv    = 1'b1;
    c.prescale   = 1'b1;
    c.rfD        = DW_W'(10);
    c.rfS        = '0;
    c.rfF        = DIV_W'(48);
    c.rfM        = DIV_W'(79);
    c.ifD        = DW_W'(16);
    c.ifS        = SW_W'(2);
    c.ifF        = DIV_W'(32);
    c.ifM        = DIV_W'(79);
    return c;
  endfunction
endpackage

// File: rtl/spw_ctrl.sv
module spw_ctrl
  import spw_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int WAKE_CYCLES = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      powerEn,
  input  logic      wrFrameN,
  input  logic      serClk,
  input  logic      serData,
  output logic      portReady,
  output spStrobe_t ctl
);
  localparam int CNT_W  = $clog2(WORD_W + 2);
  localparam int WAKE_W = $clog2(WAKE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

  logic [3:0] rawIn;
  logic [3:0] stage [SYNC_STAGES];
  assign rawIn = {powerEn, wrFrameN, serClk, serData};

  // Synchronizer chain, depth picked by parameter
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= rawIn;
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= stage[g-1];
    end
  end

  logic peS, selS, clkS, datS;
  assign {peS, selS, clkS, datS} = stage[SYNC_STAGES-1];

  logic pePrev, selPrev, clkPrev;
  logic peRise, selRise, clkRise;
  logic [WAKE_W-1:0] wakeCnt;
  logic [CNT_W-1:0]  bitCnt;

  assign peRise  = peS & ~pePrev;
  assign selRise = selS & ~selPrev;
  assign clkRise = clkS & ~clkPrev;
  assign portReady = peS && (wakeCnt == '0) && !peRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pePrev  <= 1'b0;
      selPrev <= 1'b0;
      clkPrev <= 1'b0;
      wakeCnt <= '0;
      bitCnt  <= '0;
    end else begin
      pePrev  <= peS;
      selPrev <= selS;
      clkPrev <= clkS;
      if (peRise)              wakeCnt <= WAKE_W'(WAKE_CYCLES);
      else if (wakeCnt != '0)  wakeCnt <= wakeCnt - 1'b1;
      if (!portReady || selS)  bitCnt <= '0;
      else if (clkRise && bitCnt != CNT_OVER) bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    ctl.reload = peRise;
    ctl.shift  = portReady && !selS && clkRise;
    ctl.bitIn  = datS;
    ctl.commit = portReady && selRise && (bitCnt == CNT_FULL);
  end
endmodule

// File: rtl/spw_regs.sv
module spw_regs
  import spw_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 4,
  parameter int DR_MIN = 7,
  parameter int MR_MIN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  spStrobe_t         ctl,
  input  logic [GAIN_W-1:0] gainPins,
  output cfgRegs_t          cfg,
  output logic              rangeErr,
  output logic [GAIN_W-1:0] txGain,
  output logic [GAIN_W-1:0] txAttenDb,
  output logic [DW_W-1:0]   ifDOut,
  output logic [SW_W-1:0]   ifSOut,
  output logic [DIV_W-1:0]  ifFOut,
  output logic [DIV_W-1:0]  ifMOut
);
  localparam int TOP = WORD_W - 1;
  localparam logic [GAIN_W-1:0] GAIN_MAX = '1;

  logic [WORD_W-1:0] shiftReg;
  logic [ADDR_W-1:0] addr;
  cfgRegs_t nxt;
  logic nxtErr;
  logic unusedPad;

  assign addr = shiftReg[ADDR_W-1:0];
  assign unusedPad = ^shiftReg[TOP-8:ADDR_W];

  always_comb begin
    nxt = cfg;
    nxtErr = rangeErr;
    case (4'(addr))
      ADDR_MODE: begin
        nxt.psMode     = shiftReg[TOP -: PS_W];
        nxt.bandA      = shiftReg[TOP-2];
        nxt.gainSrcPin = shiftReg[TOP-3];
        nxt.fracIf     = shiftReg[TOP-4];
        nxt.txHiLin    = shiftReg[TOP-5];
        nxt.cpCont     = shiftReg[TOP-6];
        nxt.xoLowPwr   = shiftReg[TOP-7];
        nxtErr = 1'b0;
      end
      ADDR_GAIN: begin
        nxt.txGainSer = shiftReg[TOP -: GAIN_W];
        nxt.specInv   = shiftReg[TOP-GAIN_W];
        nxtErr = 1'b0;
      end
      ADDR_RFM: begin
        if (shiftReg[TOP -: DIV_W] < DIV_W'(MR_MIN)) nxtErr = 1'b1;
        else begin
          nxt.rfM = shiftReg[TOP -: DIV_W];
          nxtErr = 1'b0;
        end
      end
      ADDR_IFM: begin
        nxt.ifM = shiftReg[TOP -: DIV_W];
        nxtErr = 1'b0;
      end
      ADDR_RFF: begin
        nxt.rfF      = shiftReg[TOP -: DIV_W];
        nxt.prescale = shiftReg[TOP-DIV_W];
        nxtErr = 1'b0;
      end
      ADDR_IFF: begin
        nxt.ifF = shiftReg[TOP -: DIV_W];
        nxtErr = 1'b0;
      end
      ADDR_RFDS: begin
        if (shiftReg[TOP -: DW_W] < DW_W'(DR_MIN)) nxtErr = 1'b1;
        else begin
          nxt.rfD = shiftReg[TOP -: DW_W];
          nxt.rfS = shiftReg[TOP-DW_W -: SW_W];
          nxtErr = 1'b0;
        end
      end
      ADDR_IFDS: begin
        nxt.ifD = shiftReg[TOP -: DW_W];
        nxt.ifS = shiftReg[TOP-DW_W -: SW_W];
        nxtErr = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg      <= cfgDefaults();
      rangeErr <= 1'b0;
      shiftReg <= '0;
    end else if (ctl.reload) begin
      cfg      <= cfgDefaults();
      rangeErr <= 1'b0;
      shiftReg <= '0;
    end else begin
      if (ctl.shift) shiftReg <= {shiftReg[WORD_W-2:0], ctl.bitIn};
      if (ctl.commit) begin
        cfg      <= nxt;
        rangeErr <= nxtErr;
      end
    end
  end

  assign txGain    = cfg.gainSrcPin ? gainPins : cfg.txGainSer;
  assign txAttenDb = GAIN_MAX - txGain;
  assign ifDOut    = cfg.fracIf ? cfg.ifD : '0;
  assign ifSOut    = cfg.fracIf ? cfg.ifS : '0;
  assign ifFOut    = cfg.fracIf ? cfg.ifF : '0;
  assign ifMOut    = cfg.fracIf ? cfg.ifM : '0;
endmodule

// File: rtl/spw_port.sv
module spw_port
  import spw_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int ADDR_W      = 4,
  parameter int WAKE_CYCLES = 100,
  parameter int SYNC_STAGES = 2,
  parameter int DR_MIN      = 7,
  parameter int MR_MIN      = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        powerEn,
  input  logic        wrFrameN,
  input  logic        serClk,
  input  logic        serData,
  input  logic [4:0]  gainPins,
  output logic        portReady,
  output logic [1:0]  psMode,
  output logic        bandA,
  output logic        specInv,
  output logic        txHiLin,
  output logic        cpCont,
  output logic        xoLowPwr,
  output logic        prescale,
  output logic [4:0]  rfD,
  output logic [2:0]  rfS,
  output logic [6:0]  rfF,
  output logic [6:0]  rfM,
  output logic        ifFracOn,
  output logic [4:0]  ifD,
  output logic [2:0]  ifS,
  output logic [6:0]  ifF,
  output logic [6:0]  ifM,
  output logic        gainSrcPin,
  output logic [4:0]  txGain,
  output logic [4:0]  txAttenDb,
  output logic        rfRangeErr
);
  spStrobe_t ctl;
  cfgRegs_t  cfg;

  spw_ctrl #(.WORD_W(WORD_W), .WAKE_CYCLES(WAKE_CYCLES), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .powerEn(powerEn), .wrFrameN(wrFrameN),
    .serClk(serClk), .serData(serData), .portReady(portReady), .ctl(ctl)
  );

  spw_regs #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .DR_MIN(DR_MIN), .MR_MIN(MR_MIN)) uRegs (
    .clk(clk), .rstN(rstN), .ctl(ctl), .gainPins(gainPins), .cfg(cfg),
    .rangeErr(rfRangeErr), .txGain(txGain), .txAttenDb(txAttenDb),
    .ifDOut(ifD), .ifSOut(ifS), .ifFOut(ifF), .ifMOut(ifM)
  );

  assign psMode     = cfg.psMode;
  assign bandA      = cfg.bandA;
  assign specInv    = cfg.specInv;
  assign txHiLin    = cfg.txHiLin;
  assign cpCont     = cfg.cpCont;
  assign xoLowPwr   = cfg.xoLowPwr;
  assign prescale   = cfg.prescale;
  assign rfD        = cfg.rfD;
  assign rfS        = cfg.rfS;
  assign rfF        = cfg.rfF;
  assign rfM        = cfg.rfM;
  assign ifFracOn   = cfg.fracIf;
  assign gainSrcPin = cfg.gainSrcPin;
endmodule

// File: rtl/spw_port_chk.sv
module spw_port_chk #(
  parameter int WAKE_CYCLES = 100
) (
  input logic       clk,
  input logic       rstN,
  input logic       commit,
  input logic       reload,
  input logic [1:0] psMode,
  input logic       specInv,
  input logic       prescale,
  input logic [4:0] rfD,
  input logic [2:0] rfS,
  input logic [6:0] rfF,
  input logic [6:0] rfM,
  input logic       rfRangeErr
);
  localparam int WAKE_W = $clog2(WAKE_CYCLES + 1);
  logic [WAKE_W-1:0] sinceReload;
  logic seenReload;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceReload <= '0;
      seenReload  <= 1'b0;
    end else if (reload) begin
      sinceReload <= '0;
      seenReload  <= 1'b1;
    end else if (sinceReload != WAKE_W'(WAKE_CYCLES)) begin
      sinceReload <= sinceReload + 1'b1;
    end
  end

  // R5: no commit before the wake window has elapsed
  assert_wake_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    commit |-> (seenReload && sinceReload == WAKE_W'(WAKE_CYCLES)));

  // R4: defaults visible the cycle after a reload
  assert_reload_defaults_R4: assert property (@(posedge clk) disable iff (!rstN)
    reload |=> (rfD == 5'd10 && rfS == 3'd0 && rfF == 7'd48 && rfM == 7'd79 && prescale && !rfRangeErr));

  // R6: RF divider outputs stay in their legal span
  assert_rf_legal_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rfD >= 5'd7) && (rfM >= 7'd32));

  // R6: a rejection leaves the RF divider untouched
  assert_reject_keeps_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rfRangeErr) |-> ($stable(rfD) && $stable(rfS) && $stable(rfM)));

  // R1: configuration moves only on a commit or reload
  assert_quiet_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!commit && !reload) |=> $stable({psMode, specInv, prescale, rfD, rfS, rfF, rfM}));
endmodule

bind spw_port spw_port_chk #(.WAKE_CYCLES(WAKE_CYCLES)) uChk (
  .clk(clk), .rstN(rstN), .commit(ctl.commit), .reload(ctl.reload),
  .psMode(psMode), .specInv(specInv), .prescale(prescale),
  .rfD(rfD), .rfS(rfS), .rfF(rfF), .rfM(rfM), .rfRangeErr(rfRangeErr)
);

// File: tb/sim_spw_port.sv
`timescale 1ns/1ps
module sim_spw_port;
  localparam int WAKE = 100;

  logic clk = 1'b0, rstN = 1'b0, powerEn = 1'b0, wrFrameN = 1'b1, serClk = 1'b0, serData = 1'b0;
  logic [4:0] gainPins = 5'd0;
  logic portReady, bandA, specInv, txHiLin, cpCont, xoLowPwr, prescale, ifFracOn, gainSrcPin, rfRangeErr;
  logic [1:0] psMode;
  logic [4:0] rfD, ifD, txGain, txAttenDb;
  logic [2:0] rfS, ifS;
  logic [6:0] rfF, rfM, ifF, ifM;

  always #2.5 clk = ~clk;

  spw_port #(.WAKE_CYCLES(WAKE)) u0 (
    .clk(clk), .rstN(rstN), .powerEn(powerEn), .wrFrameN(wrFrameN), .serClk(serClk),
    .serData(serData), .gainPins(gainPins), .portReady(portReady), .psMode(psMode),
    .bandA(bandA), .specInv(specInv), .txHiLin(txHiLin), .cpCont(cpCont),
    .xoLowPwr(xoLowPwr), .prescale(prescale), .rfD(rfD), .rfS(rfS), .rfF(rfF),
    .rfM(rfM), .ifFracOn(ifFracOn), .ifD(ifD), .ifS(ifS), .ifF(ifF), .ifM(ifM),
    .gainSrcPin(gainSrcPin), .txGain(txGain), .txAttenDb(txAttenDb), .rfRangeErr(rfRangeErr)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  int mPs, mBand, mSrc, mFrac, mHi, mCp, mXo, mGs, mInv;
  int mRfM, mIfM, mRfF, mPre, mIfF, mRfD, mRfS, mIfD, mIfS, mErr;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setDefaults();
    mPs = 0; mBand = 0; mSrc = 1; mFrac = 0; mHi = 0; mCp = 0; mXo = 1;
    mGs = 0; mInv = 1; mPre = 1; mRfD = 10; mRfS = 0; mRfF = 48; mRfM = 79;
    mIfD = 16; mIfS = 2; mIfF = 32; mIfM = 79; mErr = 0;
  endtask

  // Model of an accepted 16-bit frame (R1, R3, R6)
  task automatic modelWord(logic [15:0] w);
    case (w[3:0])
      4'd1: begin mPs = w[15:14]; mBand = w[13]; mSrc = w[12]; mFrac = w[11];
                  mHi = w[10]; mCp = w[9]; mXo = w[8]; mErr = 0; end
      4'd2: begin mGs = w[15:11]; mInv = w[10]; mErr = 0; end
      4'd3: if (w[15:9] < 32) mErr = 1; else begin mRfM = w[15:9]; mErr = 0; end
      4'd4: begin mIfM = w[15:9]; mErr = 0; end
      4'd5: begin mRfF = w[15:9]; mPre = w[8]; mErr = 0; end
      4'd6: begin mIfF = w[15:9]; mErr = 0; end
      4'd7: if (w[15:11] < 7) mErr = 1; else begin mRfD = w[15:11]; mRfS = w[10:8]; mErr = 0; end
      4'd8: begin mIfD = w[15:11]; mIfS = w[10:8]; mErr = 0; end
      default: ;
    endcase
  endtask

  function automatic int expGain();
    return mSrc ? int'(gainPins) : mGs;
  endfunction

  task automatic checkAll(string req);
    chk(req, "psMode", psMode, mPs);       chk(req, "bandA", bandA, mBand);
    chk(req, "gainSrcPin", gainSrcPin, mSrc); chk(req, "ifFracOn", ifFracOn, mFrac);
    chk(req, "txHiLin", txHiLin, mHi);     chk(req, "cpCont", cpCont, mCp);
    chk(req, "xoLowPwr", xoLowPwr, mXo);   chk(req, "specInv", specInv, mInv);
    chk(req, "prescale", prescale, mPre);  chk(req, "rfD", rfD, mRfD);
    chk(req, "rfS", rfS, mRfS);            chk(req, "rfF", rfF, mRfF);
    chk(req, "rfM", rfM, mRfM);            chk(req, "rfRangeErr", rfRangeErr, mErr);
    chk(req, "ifD", ifD, mFrac ? mIfD : 0); chk(req, "ifS", ifS, mFrac ? mIfS : 0);
    chk(req, "ifF", ifF, mFrac ? mIfF : 0); chk(req, "ifM", ifM, mFrac ? mIfM : 0);
    chk(req, "txGain", txGain, expGain());  chk(req, "txAttenDb", txAttenDb, 31 - expGain());
  endtask

  task automatic sendBits(logic [31:0] w, int n);
    wrFrameN = 1'b0;
    waitClk(4);
    for (int i = n - 1; i >= 0; i--) begin
      serData = w[i];
      waitClk(3);
      serClk = 1'b1;
      waitClk(3);
      serClk = 1'b0;
    end
    waitClk(3);
    wrFrameN = 1'b1;
    waitClk(8);
  endtask

  task automatic write16(logic [15:0] w);
    sendBits({16'h0, w}, 16);
    modelWord(w);
  endtask

  task automatic powerUp();
    powerEn = 1'b1;
    waitClk(30);
    chk("R5", "portReady in wake window", portReady, 0);
    waitClk(WAKE + 10);
    chk("R5", "portReady after wake", portReady, 1);
    setDefaults();
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    setDefaults();
    waitClk(5);
    rstN = 1'b1;
    waitClk(3);
    chk("R5", "portReady while powerEn low", portReady, 0);
    checkAll("R4");
    powerUp();
    checkAll("R4");

    // R1: mode word, ps=3 band=1 src=0 frac=1 hiLin=1 cp=0 xo=0
    write16({2'b11, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 4'd1});
    checkAll("R1");
    // R7 R8: serial gain 22, pins ignored
    gainPins = 5'd3;
    write16({5'd22, 1'b0, 6'd0, 4'd2});
    chk("R7", "serial txGain", txGain, 22);
    chk("R8", "atten", txAttenDb, 9);
    gainPins = 5'd30;
    waitClk(2);
    chk("R7", "pins ignored", txGain, 22);
    // R7: switch to pins
    write16({2'b11, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 4'd1});
    chk("R7", "pin txGain", txGain, 30);
    gainPins = 5'd0;
    waitClk(2);
    chk("R8", "min gain atten", txAttenDb, 31);
    gainPins = 5'd31;
    waitClk(2);
    chk("R8", "max gain atten", txAttenDb, 0);
    // R9: IF fields with fracIf=1, then 0
    write16({5'd12, 3'd5, 4'd0, 4'd8});
    write16({7'd100, 5'd0, 4'd4});
    checkAll("R9");
    write16({2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'h0, 4'd1});
    chk("R9", "ifM gated", ifM, 0);
    checkAll("R9");
    // R6: range checks
    write16({5'd6, 3'd5, 4'd0, 4'd7});
    chk("R6", "rfD kept", rfD, 10);
    chk("R6", "flag set", rfRangeErr, 1);
    write16({5'd7, 3'd7, 4'd0, 4'd7});
    chk("R6", "rfD min", rfD, 7);
    chk("R6", "flag cleared", rfRangeErr, 0);
    write16({7'd31, 5'd0, 4'd3});
    chk("R6", "rfM kept", rfM, 79);
    chk("R6", "flag on M", rfRangeErr, 1);
    write16({7'd32, 5'd0, 4'd3});
    write16({5'd31, 3'd0, 4'd0, 4'd7});
    write16({7'd127, 5'd0, 4'd3});
    checkAll("R6");
    // R3: unknown addresses leave everything unchanged
    write16({12'hFFF, 4'd0});
    write16({12'h000, 4'd9});
    write16({12'hA5A, 4'd15});
    checkAll("R3");
    // R2: 15 and 17 clocks discarded
    sendBits({16'h0, 16'hFFF7}, 15);
    sendBits({15'h0, 1'b1, 16'h0807}, 17);
    checkAll("R2");
    // R10: stray clocks while frame select is high
    serData = 1'b1;
    for (int k = 0; k < 5; k++) begin
      serClk = 1'b1; waitClk(3); serClk = 1'b0; waitClk(3);
    end
    write16({5'd9, 3'd2, 4'd0, 4'd7});
    checkAll("R10");
    // R5: power down, frame ignored, power up reloads
    powerEn = 1'b0;
    waitClk(6);
    chk("R5", "ready low when powered off", portReady, 0);
    sendBits({16'h0, 5'd20, 3'd1, 4'd0, 4'd7}, 16);
    chk("R5", "write while off ignored", rfD, 9);
    powerEn = 1'b1;
    waitClk(10);
    sendBits({16'h0, 5'd20, 3'd1, 4'd0, 4'd7}, 16);
    waitClk(WAKE);
    setDefaults();
    checkAll("R4");
    // Random mix: R1 R2 R3 R6 R7
    for (int it = 0; it < 80; it++) begin
      logic [15:0] w;
      int n;
      w = 16'($urandom());
      n = (($urandom() % 8) == 0) ? 15 + 2 * int'($urandom() % 2) : 16;
      gainPins = 5'($urandom());
      if (n == 16) write16(w);
      else sendBits({16'h0, w}, n);
      checkAll("R1");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule